// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog peripheral built around an 8-bit up-counter. Software reaches it over a small register bus that has an address, 16-bit write data, byte-wide read data, and separate write and read strobes. It has three registers: timer control, counter, and reset control. Every write carries an access key in its upper byte. A write whose key does not match the target register changes nothing. A prescaler with eight selectable ratios sets how fast the counter advances.

In watchdog mode, the counter rolls over from 255 and sets a sticky overflow flag. If reset generation is enabled, the block also drives a reset pulse of fixed length toward the system. Software keeps the system alive by writing zero into the counter before it wraps. The overflow flag resists accidental clearing: the clear word works only after software has read the flag while it was set.

Top module: `keyed_watchdog`

## Requirements
- R1: A write at offset 0x0 with upper byte 0xA5 loads the watchdog-mode bit (data bit 6), the run bit (data bit 5) and the divider select (data bits 2:0). A write with any other upper byte leaves the register unchanged. A byte read at 0x0 returns {0, mode, run, 00, select}.
- R2: A write at offset 0x2 with upper byte 0x5A loads the low data byte into the counter. A write with any other upper byte is ignored. A byte read at 0x2 returns the counter.
- R3: A write at offset 0x4 with upper byte 0x5A sets the reset-enable bit from data bit 6. A byte read at 0x4 returns {overflow flag, reset enable, 000000}.
- R4: While running, the counter increments once every N clocks. Divider selects 0 through 7 give N = 1, 64, 128, 256, 512, 1024, 4096 and 16384. A counter write restarts the prescaler.
- R5: Clearing the run bit, for example by writing 0xA500 at 0x0, freezes the counter.
- R6: When the counter wraps from 255 to 0 in watchdog mode, the overflow flag becomes 1. The flag stays at 1 until it is cleared.
- R7: Writing exactly 0xA500 at 0x4 clears the flag only if a read at 0x4 has returned the flag set since the last successful clear or reset. A successful clear consumes that read.
- R8: A watchdog-mode wrap with reset enable set drives `wdt_rst` high for 16 clocks, starting the cycle after the wrap.
- R9: With watchdog mode off, the counter wraps without setting the flag and without a reset pulse.
- R10: After reset, all registers read 0 and `wdt_rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register byte offset |
| wdata | input | 16 | Write data: key byte in bits 15:8 |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (arms the flag clear) |
| rdata | output | 8 | Register read data for `addr` |
| wdt_rst | output | 1 | System reset pulse |

## Verification
The assertions assume that each strobe lasts one cycle and addresses one register. They also assume that `wdata` is stable for the whole strobe cycle. The random stimulus drives every input once per cycle, at the falling edge. It mixes correct keys, wrong keys, the exact clear word and reads of the flag register, so that both the accepted and the ignored paths are exercised.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int          AW       = 3,
  parameter int          RST_LEN  = 16,
  parameter logic [7:0]  KEY_CTL  = 8'hA5,
  parameter logic [7:0]  KEY_CNT  = 8'h5A,
  parameter logic [7:0]  KEY_RST  = 8'h5A,
  parameter logic [15:0] CLR_WORD = 16'hA500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [7:0]    rdata,
  output logic          wdt_rst
);
  localparam int PRE_W = 14;
  localparam int RL_W  = $clog2(RST_LEN + 1);
  localparam logic [AW-1:0] A_CTL = AW'(0);
  localparam logic [AW-1:0] A_CNT = AW'(2);
  localparam logic [AW-1:0] A_RST = AW'(4);

  logic             ctl_mode, ctl_run, rst_en, ovf_flag, flag_seen;
  logic [2:0]       ctl_sel;
  logic [7:0]       cnt;
  logic [PRE_W-1:0] pre, pre_lim;
  logic [RL_W-1:0]  rst_left;

  wire wr_ctl = wr_en && addr == A_CTL && wdata[15:8] == KEY_CTL;
  wire wr_cnt = wr_en && addr == A_CNT && wdata[15:8] == KEY_CNT;
  wire wr_rst = wr_en && addr == A_RST && wdata[15:8] == KEY_RST;
  wire clr_ok = wr_en && addr == A_RST && wdata == CLR_WORD && flag_seen;
  wire rd_flag = rd_en && addr == A_RST && ovf_flag;

  always_comb begin
    case (ctl_sel)
      3'd0:    pre_lim = PRE_W'(0);
      3'd1:    pre_lim = PRE_W'(63);
      3'd2:    pre_lim = PRE_W'(127);
      3'd3:    pre_lim = PRE_W'(255);
      3'd4:    pre_lim = PRE_W'(511);
      3'd5:    pre_lim = PRE_W'(1023);
      3'd6:    pre_lim = PRE_W'(4095);
      default: pre_lim = PRE_W'(16383);
    endcase
  end

  wire tick   = ctl_run && pre == pre_lim;
  wire wrap   = tick && cnt == 8'hFF && !wr_cnt;
  wire wd_ovf = wrap && ctl_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_mode <= 1'b0;
      ctl_run  <= 1'b0;
      ctl_sel  <= 3'd0;
    end else if (wr_ctl) begin
      ctl_mode <= wdata[6];
      ctl_run  <= wdata[5];
      ctl_sel  <= wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pre <= '0;
    else if (!ctl_run || wr_cnt || tick) pre <= '0;
    else                              pre <= pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= 8'd0;
    else if (wr_cnt) cnt <= wdata[7:0];
    else if (tick)   cnt <= cnt + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag  <= 1'b0;
      flag_seen <= 1'b0;
      rst_en    <= 1'b0;
    end else begin
      if (wd_ovf)      ovf_flag <= 1'b1;
      else if (clr_ok) ovf_flag <= 1'b0;
      if (clr_ok)       flag_seen <= 1'b0;
      else if (rd_flag) flag_seen <= 1'b1;
      if (wr_rst) rst_en <= wdata[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rst_left <= '0;
    else if (wd_ovf && rst_en) rst_left <= RL_W'(RST_LEN);
    else if (rst_left != '0)   rst_left <= rst_left - 1'b1;
  end

  assign wdt_rst = rst_left != '0;

  always_comb begin
    case (addr)
      A_CTL:   rdata = {1'b0, ctl_mode, ctl_run, 2'b00, ctl_sel};
      A_CNT:   rdata = cnt;
      A_RST:   rdata = {ovf_flag, rst_en, 6'd0};
      default: rdata = 8'd0;
    endcase
  end
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
  parameter int AW = 3,
  parameter int RST_LEN = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic [15:0]   wdata,
  input logic          wr_en,
  input logic          ctl_mode,
  input logic          ctl_run,
  input logic [2:0]    ctl_sel,
  input logic [7:0]    cnt,
  input logic          ovf_flag,
  input logic          flag_seen,
  input logic          rst_en,
  input logic          wdt_rst
);
  AST_CTRL_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(0) && wdata[15:8] != 8'hA5) |=> $stable({ctl_mode, ctl_run, ctl_sel})); // R1
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_run && !(wr_en && addr == AW'(2))) |=> $stable(cnt)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(wr_en && addr == AW'(4) && wdata == 16'hA500)) |=> ovf_flag); // R6
  AST_CLR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> $past(flag_seen)); // R7
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> $past(ctl_mode && rst_en)); // R8
  AST_RST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> ovf_flag); // R6
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.AW(AW), .RST_LEN(RST_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .ctl_mode(ctl_mode), .ctl_run(ctl_run), .ctl_sel(ctl_sel), .cnt(cnt),
  .ovf_flag(ovf_flag), .flag_seen(flag_seen), .rst_en(rst_en), .wdt_rst(wdt_rst)
);

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [15:0] wdata = 16'd0;
  logic [7:0] rdata;
  logic wdt_rst;
  int checks = 0, errors = 0;
  bit done = 0;

  keyed_watchdog u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
                     .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .wdt_rst(wdt_rst));

  always #(CLK_PERIOD/2) clk = ~clk;

  bit m_mode, m_run, m_rsten, m_ovf, m_seen;
  bit [2:0] m_sel;
  bit [7:0] m_cnt;
  int m_pre, m_left;

  function automatic int ratio(bit [2:0] s);
    case (s)
      3'd0: return 1;     3'd1: return 64;   3'd2: return 128;  3'd3: return 256;
      3'd4: return 512;   3'd5: return 1024; 3'd6: return 4096; default: return 16384;
    endcase
  endfunction

  function automatic bit [7:0] m_read(bit [2:0] a);
    if (a == 3'd0) return {1'b0, m_mode, m_run, 2'b00, m_sel};
    if (a == 3'd2) return m_cnt;
    if (a == 3'd4) return {m_ovf, m_rsten, 6'd0};
    return 8'd0;
  endfunction

  function automatic void m_step(bit w, bit r, bit [2:0] a, bit [15:0] d);
    bit cw, tk, ov, clr;
    cw  = w && a == 3'd2 && d[15:8] == 8'h5A;
    tk  = m_run && (m_pre == ratio(m_sel) - 1);
    ov  = tk && m_cnt == 8'hFF && !cw && m_mode;
    clr = w && a == 3'd4 && d == 16'hA500 && m_seen;
    if (ov && m_rsten) m_left = 16; else if (m_left > 0) m_left--;
    if (ov) m_ovf = 1; else if (clr) m_ovf = 0;
    if (clr) m_seen = 0; else if (r && a == 3'd4 && m_ovf && !ov) m_seen = 1;
    if (cw) m_cnt = d[7:0]; else if (tk) m_cnt = m_cnt + 8'd1;
    m_pre = (!m_run || cw || tk) ? 0 : m_pre + 1;
    if (w && a == 3'd4 && d[15:8] == 8'h5A) m_rsten = d[6];
    if (w && a == 3'd0 && d[15:8] == 8'hA5) begin
      m_mode = d[6]; m_run = d[5]; m_sel = d[2:0];
    end
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic op(bit w, bit r, bit [2:0] a, bit [15:0] d);
    bit [7:0] exp_rd;
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #1;
    exp_rd = m_read(a);
    if (r) chk(a == 3'd0 ? "R1 read" : a == 3'd2 ? "R2 read" : "R3 read", rdata, exp_rd);
    chk("R8 reset pin", wdt_rst, m_left > 0);
    @(posedge clk);
    m_step(w, r, a, d);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) op(0, 0, 3'd0, 16'd0);
  endtask

  task automatic peek(string tag, bit [2:0] a, bit [7:0] exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int pulse;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek("R10 ctrl", 3'd0, 8'h00);
    peek("R10 cnt", 3'd2, 8'h00);
    peek("R10 rstctl", 3'd4, 8'h00);
    chk("R10 pin", wdt_rst, 0);

    op(1, 0, 3'd0, 16'h1265);
    peek("R1 wrong key", 3'd0, 8'h00);
    op(1, 0, 3'd2, 16'h1211);
    peek("R2 wrong key", 3'd2, 8'h00);
    op(1, 0, 3'd2, 16'h5A37);
    peek("R2 load", 3'd2, 8'h37);

    op(1, 0, 3'd0, 16'hA562);
    peek("R1 fields", 3'd0, 8'h62);
    op(1, 0, 3'd2, 16'h5A00);
    idle(383);
    peek("R4 div128 before", 3'd2, 8'h02);
    idle(1);
    peek("R4 div128", 3'd2, 8'h03);
    op(1, 0, 3'd0, 16'hA500);
    idle(500);
    peek("R5 frozen", 3'd2, 8'h03);

    op(1, 0, 3'd0, 16'hA527);
    op(1, 0, 3'd2, 16'h5AFE);
    idle(16384);
    peek("R4 div16384", 3'd2, 8'hFF);
    op(1, 0, 3'd0, 16'hA500);

    op(1, 0, 3'd0, 16'hA520);
    op(1, 0, 3'd2, 16'h5AFE);
    idle(3);
    peek("R9 wrap count", 3'd2, 8'h01);
    peek("R9 no flag", 3'd4, 8'h00);
    chk("R9 no pulse", wdt_rst, 0);
    op(1, 0, 3'd0, 16'hA500);

    op(1, 0, 3'd4, 16'h5A40);
    peek("R3 rsten", 3'd4, 8'h40);
    op(1, 0, 3'd0, 16'hA560);
    op(1, 0, 3'd2, 16'h5AFF);
    op(1, 0, 3'd0, 16'hA500);
    peek("R6 flag", 3'd4, 8'hC0);
    pulse = 0;
    for (int i = 0; i < 40; i++) begin
      #1; if (wdt_rst) pulse++;
      op(0, 0, 3'd0, 16'd0);
    end
    chk("R8 pulse length", pulse, 16);

    op(1, 0, 3'd4, 16'hA500);
    peek("R7 clear refused", 3'd4, 8'hC0);
    op(0, 1, 3'd4, 16'd0);
    op(1, 0, 3'd4, 16'hA501);
    peek("R7 inexact word", 3'd4, 8'hC0);
    op(1, 0, 3'd4, 16'hA500);
    peek("R7 cleared", 3'd4, 8'h40);

    for (int i = 0; i < 20000; i++) begin
      int k;
      bit [7:0] key;
      k = $urandom % 12;
      key = ($urandom % 5 == 0) ? 8'($urandom) : 8'h00;
      case (k)
        0: op(1, 0, 3'd0, {(key != 0 ? key : 8'hA5), 1'b0, 1'($urandom), 1'($urandom), 2'b00, 3'($urandom % 4)});
        1: op(1, 0, 3'd2, {(key != 0 ? key : 8'h5A), ($urandom % 2) ? 8'hFF : 8'($urandom)});
        2: op(1, 0, 3'd4, ($urandom % 2) ? 16'hA500 : {(key != 0 ? key : 8'h5A), 1'b0, 1'($urandom), 6'd0});
        3, 4, 5: op(0, 1, 3'd4, 16'd0);
        default: op(0, 1, 3'(2 * ($urandom % 3)), 16'd0);
      endcase
    end
    finish_run();
  end
endmodule